// File: doc/BRIEF.md
# Dirty Page Display Update Tracker

This block keeps one dirty flag per 4096-byte page of a framebuffer whose line stride is fixed at 1024 bytes. Every page therefore covers four consecutive scanlines. Byte write addresses from the memory side mark their page dirty. A single invalidate strobe marks the whole 1024x768 area dirty.

A refresh strobe starts a scan that walks the pages from the top of the frame down to the programmed height. For every dirty page it issues four line-fetch requests, one per cycle, so the pixel path can redraw those lines. Consecutive dirty pages are merged into a single update rectangle that spans the full visible width. The rectangle goes out on a valid/ready port when the run ends, either at a clean page or at the end of the scan. The scan waits while a rectangle is held. After the scan, the dirty flags from the lowest to the highest dirty page seen are cleared. Writes that arrive during a scan are parked and merged after that clear, so no modification is lost.

Top module: `dirty_rect_tracker`

## Requirements
- R1: After reset every page is clean. `busy`, `rect_valid` and `fetch_valid` are low, and a refresh produces no rectangle and no fetch.
- R2: A write at byte address A marks page A/4096 (address bits 19:12) dirty. A write at an address of 786432 or above changes no page.
- R3: Every dirty page p that is scanned yields fetch requests for lines 4p, 4p+1, 4p+2 and 4p+3, in that order, on consecutive cycles.
- R4: A run of consecutive dirty pages becomes one rectangle. Its start line is the first line of the run and its height is 4 lines per page. Its width is the `cfg_width` captured at refresh, and it starts at column 0. It is emitted when the first clean page after the run is reached.
- R5: A run still open when the scan passes its last page is emitted with an end line equal to the first line of the first unscanned page. That is 4*ceil(height/4), capped at 768.
- R6: A scan visits exactly the pages whose first line is below the `cfg_height` captured at refresh. Dirty pages beyond that stay dirty for a later scan.
- R7: After a scan, every page it found dirty is clean. An immediate second refresh emits nothing.
- R8: An invalidate pulse makes all 192 pages dirty.
- R9: Writes and invalidates accepted while `busy` is high are not drawn by the running scan. They are kept and drawn by the next one.
- R10: While `rect_valid` is high and `rect_ready` is low, the rectangle fields stay stable and no fetch request is issued.
- R11: A refresh pulse while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | A framebuffer byte write happened this cycle |
| wr_addr | input | 20 | Byte address of that write within the framebuffer |
| invalidate | input | 1 | Mark every page dirty |
| refresh | input | 1 | Start a scan (ignored while busy) |
| cfg_height | input | 10 | Visible height in lines, captured at refresh |
| cfg_width | input | 11 | Visible width in pixels, captured at refresh |
| busy | output | 1 | A scan is running |
| rect_valid | output | 1 | An update rectangle is offered |
| rect_ready | input | 1 | The sink accepts the rectangle |
| rect_y | output | 10 | First line of the rectangle |
| rect_h | output | 10 | Number of lines in the rectangle |
| rect_w | output | 11 | Rectangle width (column 0 onward) |
| fetch_valid | output | 1 | A line fetch request is issued this cycle |
| fetch_line | output | 10 | Line to fetch and redraw |

## Verification
The patterns are chosen to separate run merging from run splitting. A lone dirty page is tried first. A mixed pattern follows, with a three-page run at line 0, an isolated page and a two-page run, plus an out-of-range address that must not alias into the visible frame. A short programmed height shows where the final rectangle ends and that pages beyond the scan stay dirty. A full invalidate then checks the single 768-line rectangle under a throttled ready. A repeat refresh right after each scan shows the clear. Writes and a second refresh issued during a scan show that late changes are deferred and that a refresh is not restarted.

// File: rtl/dpt_pkg.sv
package dpt_pkg;

    localparam int LINE_BYTES     = 1024;
    localparam int PAGE_BYTES     = 4096;
    localparam int MAX_LINES      = 768;
    localparam int MAX_WIDTH      = 1024;

    localparam int LINES_PER_PAGE = PAGE_BYTES / LINE_BYTES;
    localparam int NUM_PAGES      = MAX_LINES / LINES_PER_PAGE;
    localparam int ADDR_W         = $clog2(LINE_BYTES * MAX_LINES);
    localparam int OFF_W          = $clog2(PAGE_BYTES);
    localparam int PAGE_W         = $clog2(NUM_PAGES + 1);
    localparam int LINE_W         = $clog2(MAX_LINES + 1);
    localparam int WIDTH_W        = $clog2(MAX_WIDTH + 1);
    localparam int SUB_W          = $clog2(LINES_PER_PAGE);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_FETCH,
        ST_EMIT,
        ST_CLEAR
    } scan_state_e;

    typedef struct packed {
        logic [LINE_W-1:0] y;
        logic [LINE_W-1:0] h;
    } rect_t;

    typedef struct packed {
        logic              en;
        logic              any;
        logic [PAGE_W-1:0] lo;
        logic [PAGE_W-1:0] hi;
    } clear_cmd_t;

    function automatic logic [LINE_W-1:0] first_line(input logic [PAGE_W-1:0] pg);
        return LINE_W'(pg) << SUB_W;
    endfunction

endpackage

// File: rtl/dpt_addr_decode.sv
module dpt_addr_decode
    import dpt_pkg::*;
(
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic              set_en,
    output logic [PAGE_W-1:0] set_page
);
    logic [ADDR_W-OFF_W-1:0] page_raw;

    assign page_raw = wr_addr[ADDR_W-1:OFF_W];
    assign set_page = PAGE_W'(page_raw);
    assign set_en   = wr_valid && (PAGE_W'(page_raw) < PAGE_W'(NUM_PAGES));

endmodule

// File: rtl/dpt_dirty_store.sv
module dpt_dirty_store
    import dpt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              set_en,
    input  logic [PAGE_W-1:0] set_page,
    input  logic              inv,
    input  logic              hold,
    input  clear_cmd_t        clr,
    input  logic [PAGE_W-1:0] rd_page,
    output logic              rd_dirty
);
    logic [NUM_PAGES-1:0] dirty;
    logic [NUM_PAGES-1:0] pend;
    logic [NUM_PAGES-1:0] set_vec;
    logic [NUM_PAGES-1:0] clr_mask;

    for (genvar i = 0; i < NUM_PAGES; i++) begin : g_page
        assign set_vec[i]  = inv || (set_en && (set_page == PAGE_W'(i)));
        assign clr_mask[i] = clr.any && (PAGE_W'(i) >= clr.lo) && (PAGE_W'(i) <= clr.hi);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dirty <= '0;
            pend  <= '0;
        end else if (clr.en) begin
            dirty <= (dirty & ~clr_mask) | pend | set_vec;
            pend  <= '0;
        end else if (hold) begin
            pend  <= pend | set_vec;
        end else begin
            dirty <= dirty | set_vec;
        end
    end

    assign rd_dirty = (rd_page < PAGE_W'(NUM_PAGES)) ? dirty[rd_page] : 1'b0;

    // R9
    pend_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!hold && !clr.en) |-> (pend == '0));

    // R2
    write_lands_chk: assert property (@(posedge clk) disable iff (rst)
        (set_en && !hold && !clr.en) |=> dirty[$past(set_page)]);

endmodule

// File: rtl/dpt_scanner.sv
module dpt_scanner
    import dpt_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               refresh,
    input  logic [LINE_W-1:0]  cfg_height,
    input  logic [WIDTH_W-1:0] cfg_width,
    input  logic               rd_dirty,
    output logic [PAGE_W-1:0]  rd_page,
    output logic               busy,
    output logic               rect_valid,
    input  logic               rect_ready,
    output rect_t              rect_q,
    output logic [WIDTH_W-1:0] rect_w,
    output logic               fetch_valid,
    output logic [LINE_W-1:0]  fetch_line,
    output clear_cmd_t         clr
);
    scan_state_e        state;
    logic [PAGE_W-1:0]  page;
    logic [SUB_W-1:0]   fcnt;
    logic               run_open;
    logic [LINE_W-1:0]  y_start;
    logic [PAGE_W-1:0]  lo_pg;
    logic [PAGE_W-1:0]  hi_pg;
    logic               any_seen;
    logic               last_rect;
    logic [LINE_W-1:0]  cur_h;
    logic [WIDTH_W-1:0] cur_w;
    logic [LINE_W-1:0]  y_cur;
    logic               in_range;

    assign y_cur    = first_line(page);
    assign in_range = (page < PAGE_W'(NUM_PAGES)) && (y_cur < cur_h);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            page      <= '0;
            fcnt      <= '0;
            run_open  <= 1'b0;
            y_start   <= '0;
            lo_pg     <= '0;
            hi_pg     <= '0;
            any_seen  <= 1'b0;
            last_rect <= 1'b0;
            cur_h     <= '0;
            cur_w     <= '0;
            rect_q    <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (refresh) begin
                        cur_h    <= cfg_height;
                        cur_w    <= cfg_width;
                        page     <= '0;
                        run_open <= 1'b0;
                        any_seen <= 1'b0;
                        state    <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    if (!in_range) begin
                        if (run_open) begin
                            rect_q.y  <= y_start;
                            rect_q.h  <= y_cur - y_start;
                            run_open  <= 1'b0;
                            last_rect <= 1'b1;
                            state     <= ST_EMIT;
                        end else begin
                            state <= ST_CLEAR;
                        end
                    end else if (rd_dirty) begin
                        if (!run_open) begin
                            run_open <= 1'b1;
                            y_start  <= y_cur;
                        end
                        if (!any_seen) begin
                            any_seen <= 1'b1;
                            lo_pg    <= page;
                        end
                        hi_pg <= page;
                        fcnt  <= '0;
                        state <= ST_FETCH;
                    end else if (run_open) begin
                        rect_q.y  <= y_start;
                        rect_q.h  <= y_cur - y_start;
                        run_open  <= 1'b0;
                        last_rect <= 1'b0;
                        state     <= ST_EMIT;
                    end else begin
                        page <= page + 1'b1;
                    end
                end
                ST_FETCH: begin
                    fcnt <= fcnt + 1'b1;
                    if (fcnt == SUB_W'(LINES_PER_PAGE - 1)) begin
                        page  <= page + 1'b1;
                        state <= ST_CHECK;
                    end
                end
                ST_EMIT: begin
                    if (rect_ready) begin
                        if (last_rect) begin
                            state <= ST_CLEAR;
                        end else begin
                            page  <= page + 1'b1;
                            state <= ST_CHECK;
                        end
                    end
                end
                ST_CLEAR: state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    assign rd_page     = page;
    assign busy        = (state != ST_IDLE);
    assign rect_valid  = (state == ST_EMIT);
    assign rect_w      = cur_w;
    assign fetch_valid = (state == ST_FETCH);
    assign fetch_line  = y_cur + LINE_W'(fcnt);
    assign clr.en      = (state == ST_CLEAR);
    assign clr.any     = any_seen;
    assign clr.lo      = lo_pg;
    assign clr.hi      = hi_pg;

    // R10
    rect_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rect_valid && !rect_ready) |=> (rect_valid && $stable(rect_q) && !fetch_valid));

    // R3
    fetch_step_chk: assert property (@(posedge clk) disable iff (rst)
        (fetch_valid && $past(fetch_valid)) |-> (fetch_line == $past(fetch_line) + 1'b1));

    // R4
    rect_shape_chk: assert property (@(posedge clk) disable iff (rst)
        rect_valid |-> ((rect_q.h != '0) && (rect_q.h[SUB_W-1:0] == '0) && (rect_q.y[SUB_W-1:0] == '0)));

    // R11
    refresh_start_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && refresh) |=> busy);

endmodule

// File: rtl/dirty_rect_tracker.sv
module dirty_rect_tracker
    import dpt_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_valid,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic               invalidate,
    input  logic               refresh,
    input  logic [LINE_W-1:0]  cfg_height,
    input  logic [WIDTH_W-1:0] cfg_width,
    output logic               busy,
    output logic               rect_valid,
    input  logic               rect_ready,
    output logic [LINE_W-1:0]  rect_y,
    output logic [LINE_W-1:0]  rect_h,
    output logic [WIDTH_W-1:0] rect_w,
    output logic               fetch_valid,
    output logic [LINE_W-1:0]  fetch_line
);
    logic              set_en;
    logic [PAGE_W-1:0] set_page;
    logic [PAGE_W-1:0] rd_page;
    logic              rd_dirty;
    clear_cmd_t        clr;
    rect_t             rect_q;

    dpt_addr_decode u_decode (
        .wr_valid (wr_valid),
        .wr_addr  (wr_addr),
        .set_en   (set_en),
        .set_page (set_page)
    );

    dpt_dirty_store u_store (
        .clk      (clk),
        .rst      (rst),
        .set_en   (set_en),
        .set_page (set_page),
        .inv      (invalidate),
        .hold     (busy),
        .clr      (clr),
        .rd_page  (rd_page),
        .rd_dirty (rd_dirty)
    );

    dpt_scanner u_scan (
        .clk         (clk),
        .rst         (rst),
        .refresh     (refresh),
        .cfg_height  (cfg_height),
        .cfg_width   (cfg_width),
        .rd_dirty    (rd_dirty),
        .rd_page     (rd_page),
        .busy        (busy),
        .rect_valid  (rect_valid),
        .rect_ready  (rect_ready),
        .rect_q      (rect_q),
        .rect_w      (rect_w),
        .fetch_valid (fetch_valid),
        .fetch_line  (fetch_line),
        .clr         (clr)
    );

    assign rect_y = rect_q.y;
    assign rect_h = rect_q.h;

endmodule

// File: tb/dirty_rect_tracker_tb.sv
module dirty_rect_tracker_tb;
    import dpt_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NP = NUM_PAGES;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               wr_valid = 1'b0;
    logic [ADDR_W-1:0]  wr_addr = '0;
    logic               invalidate = 1'b0;
    logic               refresh = 1'b0;
    logic [LINE_W-1:0]  cfg_height = LINE_W'(768);
    logic [WIDTH_W-1:0] cfg_width = WIDTH_W'(800);
    logic               busy;
    logic               rect_valid;
    logic               rect_ready = 1'b1;
    logic [LINE_W-1:0]  rect_y;
    logic [LINE_W-1:0]  rect_h;
    logic [WIDTH_W-1:0] rect_w;
    logic               fetch_valid;
    logic [LINE_W-1:0]  fetch_line;

    dirty_rect_tracker u_dut (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .invalidate(invalidate), .refresh(refresh), .cfg_height(cfg_height),
        .cfg_width(cfg_width), .busy(busy), .rect_valid(rect_valid),
        .rect_ready(rect_ready), .rect_y(rect_y), .rect_h(rect_h), .rect_w(rect_w),
        .fetch_valid(fetch_valid), .fetch_line(fetch_line)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int    checks = 0;
    int    fails  = 0;
    string cur_req = "R1";
    bit    mdirty [NP];
    bit    mpend  [NP];
    bit    in_scan = 0;
    int    exp_fetch [$];
    int    exp_ry [$];
    int    exp_rh [$];
    int    exp_w = 0;
    int    ready_mode = 0;

    task automatic check(input string req, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    // Reference: expected events for one scan, and the clear it leaves behind.
    task automatic plan_scan(input int height);
        int p = 0;
        bit open = 0;
        int start = 0;
        while (p < NP && 4*p < height) begin
            if (mdirty[p]) begin
                if (!open) begin open = 1; start = 4*p; end
                for (int k = 0; k < 4; k++) exp_fetch.push_back(4*p + k);
                mdirty[p] = 0;
            end else if (open) begin
                exp_ry.push_back(start); exp_rh.push_back(4*p - start);
                open = 0;
            end
            p++;
        end
        if (open) begin
            exp_ry.push_back(start); exp_rh.push_back(4*p - start);
        end
    endtask

    task automatic do_write(input int addr);
        @(negedge clk);
        wr_valid = 1'b1; wr_addr = ADDR_W'(addr);
        @(negedge clk);
        wr_valid = 1'b0;
        if (addr < LINE_BYTES*MAX_LINES) begin
            if (in_scan) mpend[addr/PAGE_BYTES] = 1;
            else         mdirty[addr/PAGE_BYTES] = 1;
        end
    endtask

    task automatic do_invalidate();
        @(negedge clk);
        invalidate = 1'b1;
        @(negedge clk);
        invalidate = 1'b0;
        for (int i = 0; i < NP; i++) begin
            if (in_scan) mpend[i] = 1; else mdirty[i] = 1;
        end
    endtask

    task automatic start_scan(input int height, input int width);
        @(negedge clk);
        cfg_height = LINE_W'(height); cfg_width = WIDTH_W'(width);
        exp_w = width;
        plan_scan(height);
        in_scan = 1;
        refresh = 1'b1;
        @(negedge clk);
        refresh = 1'b0;
    endtask

    task automatic wait_done();
        int n = 0;
        while (busy && n < 20000) begin @(negedge clk); n++; end
        check(cur_req, busy, 0, "scan finished");
        for (int i = 0; i < NP; i++) begin
            if (mpend[i]) mdirty[i] = 1;
            mpend[i] = 0;
        end
        in_scan = 0;
        check(cur_req, exp_fetch.size(), 0, "fetches left unissued");
        check(cur_req, exp_ry.size(), 0, "rectangles left unissued");
        exp_fetch.delete(); exp_ry.delete(); exp_rh.delete();
    endtask

    // Ready driver
    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk); #1;
            cyc++;
            rect_ready = (ready_mode == 0) ? 1'b1 : ((cyc % 3) == 0);
        end
    end

    // Per-clock comparison against the reference queues
    bit               prev_stall = 0;
    logic [LINE_W-1:0] prev_y, prev_h;
    always @(negedge clk) begin
        if (!rst) begin
            if (prev_stall) begin
                check("R10", int'(rect_valid), 1, "rect held while not ready");
                check("R10", int'(rect_y), int'(prev_y), "rect_y stable");
                check("R10", int'(rect_h), int'(prev_h), "rect_h stable");
                check("R10", int'(fetch_valid), 0, "no fetch during stall");
            end
            prev_stall = rect_valid && !rect_ready;
            prev_y = rect_y; prev_h = rect_h;
            if (fetch_valid) begin
                if (exp_fetch.size() == 0) check("R3", int'(fetch_line), -1, "unexpected fetch");
                else check("R3", int'(fetch_line), exp_fetch.pop_front(), "fetch line");
            end
            if (rect_valid && rect_ready) begin
                if (exp_ry.size() == 0) check(cur_req, int'(rect_y), -1, "unexpected rectangle");
                else begin
                    check(cur_req, int'(rect_y), exp_ry.pop_front(), "rect_y");
                    check(cur_req, int'(rect_h), exp_rh.pop_front(), "rect_h");
                    check("R4", int'(rect_w), exp_w, "rect_w");
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog R1..all: actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < NP; i++) begin mdirty[i] = 0; mpend[i] = 0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state and empty scan
        cur_req = "R1";
        check("R1", int'(busy), 0, "busy after reset");
        check("R1", int'(rect_valid), 0, "rect_valid after reset");
        check("R1", int'(fetch_valid), 0, "fetch_valid after reset");
        start_scan(768, 800);
        wait_done();

        // R3/R4: a lone dirty page
        cur_req = "R4";
        do_write(5*4096 + 100);
        start_scan(768, 800);
        wait_done();

        // R4/R2: mixed runs and an out-of-range address
        cur_req = "R2";
        do_write(0); do_write(4096 + 7); do_write(2*4096 + 4095);
        do_write(7*4096);
        do_write(9*4096 + 12); do_write(10*4096);
        do_write(32'hC4000);
        start_scan(768, 640);
        wait_done();

        // R7: the clear left nothing behind
        cur_req = "R7";
        start_scan(768, 640);
        wait_done();

        // R5/R6: short height, final run past height, page beyond stays dirty
        cur_req = "R5";
        do_write(2*4096); do_write(50*4096);
        start_scan(10, 320);
        wait_done();
        cur_req = "R6";
        start_scan(768, 320);
        wait_done();

        // R9/R11: writes and a refresh during a scan
        cur_req = "R9";
        do_write(100*4096);
        start_scan(768, 1024);
        do_write(1*4096 + 3);
        do_write(150*4096);
        cur_req = "R11";
        @(negedge clk); refresh = 1'b1;
        @(negedge clk); refresh = 1'b0;
        wait_done();
        cur_req = "R9";
        start_scan(768, 1024);
        wait_done();

        // R8/R10: invalidate, full-frame rectangle under throttled ready
        cur_req = "R8";
        ready_mode = 1;
        do_write(20*4096);
        start_scan(768, 1024);
        wait_done();
        do_invalidate();
        start_scan(768, 1024);
        wait_done();
        ready_mode = 0;
        cur_req = "R7";
        start_scan(768, 1024);
        wait_done();

        summary();
        $finish;
    end

endmodule